// File: doc/BRIEF.md
# Memory-to-Frame Transmit DMA

This block fetches one transmit frame from memory and hands it to a link-layer transmitter as a stream of 32-bit words. A single-cycle `start` supplies the base address, a payload length in 32-bit words and a frame-type bit. The block acts as a read master on a 256-bit memory bus. It issues fixed-length 16-beat read bursts into a beat FIFO. A word unpacker splits each buffered 256-bit beat into eight words and forwards them under valid/ready handshaking. For a data frame, one header word is placed ahead of the payload.

The burst issuer is a four-state machine. `ISS_IDLE` moves to `ISS_WAIT_ROOM` on an accepted start when at least one burst is needed. `ISS_WAIT_ROOM` moves to `ISS_ADDR` once the FIFO level leaves room for a whole burst. `ISS_ADDR` moves to `ISS_DATA` when the address is accepted. `ISS_DATA` moves on the last beat, back to `ISS_WAIT_ROOM` if bursts remain, otherwise to `ISS_IDLE`. The unpacker is also a four-state machine. `UNP_IDLE` moves on an accepted start: to `UNP_HEADER` for a data frame, to `UNP_PAYLOAD` for a non-data frame with words, and to `UNP_FINISH` for an empty non-data frame. `UNP_HEADER` moves when the header is accepted, to `UNP_PAYLOAD`, or to `UNP_FINISH` when the count is zero. `UNP_PAYLOAD` moves to `UNP_FINISH` when the last word is accepted. `UNP_FINISH` returns to `UNP_IDLE` once the issuer is idle, and signals `done` in that cycle.

Beats fetched past the end of the frame are accepted from the bus and dropped, so they never enter the FIFO.

Top module: `frame_fetch_dma`

## Requirements
- R1: After reset, `busy`, `done`, `m_arvalid` and `tx_valid` are low. Whenever `busy` is low, `m_arvalid` and `tx_valid` are low.
- R2: Every read request has `m_arlen` = 15 (16 beats). The k-th request of a frame (k from 0) carries address base + 512·k. The address is held stable while the request waits for `m_arready`.
- R3: A frame of N words issues exactly ceil(ceil(N/8)/16) read requests. A new request starts only while the FIFO holds no more than depth−16 beats. With the default depth of 32 and the link stalled, exactly two requests go out.
- R4: Within a 256-bit beat, words leave in little-endian order: word j is taken from bits 32j+31 down to 32j.
- R5: When `is_data` is 1, the first word sent is the header 0x00000046, with type code 0x46 in bits 7:0 and zero elsewhere. The N payload words follow it.
- R6: When `is_data` is 0, no header is sent and the first word is payload word 0.
- R7: Exactly N payload words are sent. Words and beats beyond N in the last fetched data are discarded, including when N is an exact multiple of 8 or of 128, and when N is one past such a multiple.
- R8: `done` is a one-cycle pulse. It comes after the last word of the frame is accepted, and `busy` is low in the following cycle.
- R9: A `start` while `busy` is high is ignored, and the running frame completes unchanged.
- R10: A word count of zero issues no read request. A non-data frame then finishes with no words sent. A data frame sends only the header.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` is unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one frame |
| base_addr | input | 32 | Frame base address, 512-byte aligned |
| word_count | input | 16 | Payload length in 32-bit words |
| is_data | input | 1 | 1 = data frame (header inserted), 0 = other frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request accepted |
| m_araddr | output | 32 | Read burst address |
| m_arlen | output | 8 | Burst length minus one (15) |
| m_rvalid | input | 1 | Read beat valid |
| m_rready | output | 1 | Read beat accepted |
| m_rdata | input | 256 | Read beat data |
| m_rlast | input | 1 | Last beat of burst |
| tx_valid | output | 1 | Word valid toward link layer |
| tx_ready | input | 1 | Link layer accepts word |
| tx_data | output | 32 | Word toward link layer |

## Verification
The hardest condition to reach is the issuer waiting in `ISS_WAIT_ROOM` with the FIFO above its threshold. The link must stall long enough for two whole bursts to land while more are still owed. The bench starts a 1024-word frame with `tx_ready` held low for 400 cycles, counts the read requests the memory model accepts, and then releases the link and checks the full word stream. Count boundaries such as 128 and 129 words, zero-length frames, and a start given while busy drive the unpacker through the early transitions into `UNP_FINISH`.

// File: rtl/frame_dma_pkg.sv
package frame_dma_pkg;

    typedef enum logic [1:0] {
        ISS_IDLE,
        ISS_WAIT_ROOM,
        ISS_ADDR,
        ISS_DATA
    } iss_state_t;

    typedef enum logic [1:0] {
        UNP_IDLE,
        UNP_HEADER,
        UNP_PAYLOAD,
        UNP_FINISH
    } unp_state_t;

    localparam logic [7:0] HDR_TYPE_CODE = 8'h46;

endpackage

// File: rtl/fdma_beat_fifo.sv
module fdma_beat_fifo #(
    parameter int WIDTH = 256,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                level <= level + 1'b1;
            end else if (pop && !push) begin
                level <= level - 1'b1;
            end
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

endmodule

// File: rtl/fdma_burst_issuer.sv
module fdma_burst_issuer
    import frame_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 256,
    parameter int BEAT_WORDS = 8,
    parameter int BURST_LEN  = 16,
    localparam int BEAT_SH     = $clog2(BEAT_WORDS),
    localparam int BURST_SH    = $clog2(BURST_LEN),
    localparam int BURST_BYTES = BURST_LEN * DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              room_ok,
    input  logic              fifo_full,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [7:0]        arlen,
    input  logic              rvalid,
    input  logic              rlast,
    output logic              rready,
    output logic              fifo_push,
    output logic              idle
);

    iss_state_t state, state_nx;

    logic [CNT_W:0]      beats_calc;
    logic [CNT_W:0]      bursts_calc;
    logic [CNT_W:0]      beats_need;
    logic [CNT_W:0]      bursts_left;
    logic [CNT_W:0]      beat_idx;
    logic [ADDR_W-1:0]   addr_q;
    logic                beat_keep;
    logic                r_fire;

    assign beats_calc  = ({1'b0, word_count} + (CNT_W+1)'(BEAT_WORDS - 1)) >> BEAT_SH;
    assign bursts_calc = (beats_calc + (CNT_W+1)'(BURST_LEN - 1)) >> BURST_SH;
    assign beat_keep   = (beat_idx < beats_need);
    assign r_fire      = rvalid && rready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ISS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ISS_IDLE: begin
                if (start && (bursts_calc != '0)) begin
                    state_nx = ISS_WAIT_ROOM;
                end
            end
            ISS_WAIT_ROOM: begin
                if (room_ok) begin
                    state_nx = ISS_ADDR;
                end
            end
            ISS_ADDR: begin
                if (arready) begin
                    state_nx = ISS_DATA;
                end
            end
            ISS_DATA: begin
                if (r_fire && rlast) begin
                    state_nx = (bursts_left == (CNT_W+1)'(1)) ? ISS_IDLE : ISS_WAIT_ROOM;
                end
            end
            default: state_nx = ISS_IDLE;
        endcase
    end

    always_comb begin
        arvalid   = (state == ISS_ADDR);
        rready    = (state == ISS_DATA) && (!fifo_full || !beat_keep);
        fifo_push = (state == ISS_DATA) && rvalid && rready && beat_keep;
        idle      = (state == ISS_IDLE);
        araddr    = addr_q;
        arlen     = 8'(BURST_LEN - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            beats_need  <= '0;
            bursts_left <= '0;
            beat_idx    <= '0;
        end else begin
            if (state == ISS_IDLE && start) begin
                addr_q      <= base_addr;
                beats_need  <= beats_calc;
                bursts_left <= bursts_calc;
                beat_idx    <= '0;
            end
            if (state == ISS_ADDR && arready) begin
                addr_q <= addr_q + ADDR_W'(BURST_BYTES);
            end
            if (state == ISS_DATA && r_fire) begin
                beat_idx <= beat_idx + 1'b1;
                if (rlast) begin
                    bursts_left <= bursts_left - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fdma_word_unpacker.sv
module fdma_word_unpacker
    import frame_dma_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int BEAT_WORDS = 8,
    parameter int CNT_W      = 16,
    localparam int DATA_W = WORD_W * BEAT_WORDS,
    localparam int IDX_W  = $clog2(BEAT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_data,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    output logic              fifo_pop,
    input  logic              issuer_idle,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_data,
    output logic              done,
    output logic              idle
);

    unp_state_t state, state_nx;

    logic [WORD_W-1:0] lane [BEAT_WORDS];
    logic [CNT_W-1:0]  remaining;
    logic [IDX_W-1:0]  lane_idx;
    logic              w_fire;
    logic              last_word;

    for (genvar g = 0; g < BEAT_WORDS; g++) begin : g_lane
        assign lane[g] = fifo_head[g*WORD_W +: WORD_W];
    end

    assign w_fire    = (state == UNP_PAYLOAD) && !fifo_empty && tx_ready;
    assign last_word = (remaining == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= UNP_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            UNP_IDLE: begin
                if (start) begin
                    if (is_data) begin
                        state_nx = UNP_HEADER;
                    end else if (word_count == '0) begin
                        state_nx = UNP_FINISH;
                    end else begin
                        state_nx = UNP_PAYLOAD;
                    end
                end
            end
            UNP_HEADER: begin
                if (tx_ready) begin
                    state_nx = (remaining == '0) ? UNP_FINISH : UNP_PAYLOAD;
                end
            end
            UNP_PAYLOAD: begin
                if (w_fire && last_word) begin
                    state_nx = UNP_FINISH;
                end
            end
            UNP_FINISH: begin
                if (issuer_idle) begin
                    state_nx = UNP_IDLE;
                end
            end
            default: state_nx = UNP_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        unique case (state)
            UNP_HEADER: begin
                tx_valid = 1'b1;
                tx_data  = WORD_W'(HDR_TYPE_CODE);
            end
            UNP_PAYLOAD: begin
                tx_valid = !fifo_empty;
                tx_data  = lane[lane_idx];
            end
            default: ;
        endcase
        fifo_pop = w_fire && (last_word || lane_idx == IDX_W'(BEAT_WORDS - 1));
        done     = (state == UNP_FINISH) && issuer_idle;
        idle     = (state == UNP_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
            lane_idx  <= '0;
        end else begin
            if (state == UNP_IDLE && start) begin
                remaining <= word_count;
                lane_idx  <= '0;
            end else if (w_fire) begin
                remaining <= remaining - 1'b1;
                lane_idx  <= fifo_pop ? '0 : lane_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 256,
    parameter int WORD_W     = 32,
    parameter int BURST_LEN  = 16,
    parameter int FIFO_DEPTH = 32,
    localparam int BEAT_WORDS = DATA_W / WORD_W,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
    localparam int AF_LEVEL   = FIFO_DEPTH - BURST_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              is_data,
    output logic              busy,
    output logic              done,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_rlast,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [WORD_W-1:0] tx_data
);

    logic              iss_idle;
    logic              unp_idle;
    logic              start_ok;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [DATA_W-1:0] fifo_head;
    logic [LVL_W-1:0]  fifo_level;
    logic              room_ok;

    assign busy     = !(iss_idle && unp_idle);
    assign start_ok = start && !busy;
    assign room_ok  = (fifo_level <= LVL_W'(AF_LEVEL));

    fdma_burst_issuer #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .BEAT_WORDS(BEAT_WORDS),
        .BURST_LEN (BURST_LEN)
    ) u_issuer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_ok),
        .base_addr (base_addr),
        .word_count(word_count),
        .room_ok   (room_ok),
        .fifo_full (fifo_full),
        .arvalid   (m_arvalid),
        .arready   (m_arready),
        .araddr    (m_araddr),
        .arlen     (m_arlen),
        .rvalid    (m_rvalid),
        .rlast     (m_rlast),
        .rready    (m_rready),
        .fifo_push (fifo_push),
        .idle      (iss_idle)
    );

    fdma_beat_fifo #(
        .WIDTH(DATA_W),
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (fifo_push),
        .din  (m_rdata),
        .pop  (fifo_pop),
        .dout (fifo_head),
        .empty(fifo_empty),
        .full (fifo_full),
        .level(fifo_level)
    );

    fdma_word_unpacker #(
        .WORD_W    (WORD_W),
        .BEAT_WORDS(BEAT_WORDS),
        .CNT_W     (CNT_W)
    ) u_unpacker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_ok),
        .is_data    (is_data),
        .word_count (word_count),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .fifo_pop   (fifo_pop),
        .issuer_idle(iss_idle),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .done       (done),
        .idle       (unp_idle)
    );

endmodule

// File: rtl/frame_fetch_dma_checker.sv
module frame_fetch_dma_checker #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LVL_W      = 6,
    parameter int BURST_LEN  = 16,
    parameter int FIFO_DEPTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic [ADDR_W-1:0] m_araddr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [WORD_W-1:0] tx_data,
    input logic [LVL_W-1:0]  fifo_level
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_arvalid && !tx_valid));

    p_ar_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    p_room_before_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_arvalid) |-> (fifo_level <= LVL_W'(FIFO_DEPTH - BURST_LEN)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

bind frame_fetch_dma frame_fetch_dma_checker #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LVL_W     (LVL_W),
    .BURST_LEN (BURST_LEN),
    .FIFO_DEPTH(FIFO_DEPTH)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .m_araddr  (m_araddr),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .fifo_level(fifo_level)
);

// File: tb/frame_fetch_dma_test.sv
`timescale 1ns/1ps
module frame_fetch_dma_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  base_addr = '0;
    logic [15:0]  word_count = '0;
    logic         is_data = 1'b0;
    logic         busy, done;
    logic         m_arvalid;
    logic         m_arready = 1'b0;
    logic [31:0]  m_araddr;
    logic [7:0]   m_arlen;
    logic         m_rvalid = 1'b0;
    logic         m_rready;
    logic [255:0] m_rdata = '0;
    logic         m_rlast = 1'b0;
    logic         tx_valid;
    logic         tx_ready = 1'b0;
    logic [31:0]  tx_data;

    int vectors = 0;
    int errors = 0;
    int ready_mode = 0;
    int cyc = 0;
    int word_cnt = 0;
    int done_cnt = 0;
    int ar_cnt = 0;
    int bad_len = 0;
    int hold_err = 0;
    logic [31:0] words [2048];
    logic [31:0] ar_log [16];
    logic        prev_hold = 1'b0;
    logic [31:0] prev_data = '0;

    always #2.5 clk = ~clk;

    frame_fetch_dma uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .is_data(is_data), .busy(busy), .done(done),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_arlen(m_arlen), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .m_rdata(m_rdata), .m_rlast(m_rlast), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] make_beat(input logic [31:0] addr, input int b);
        logic [255:0] v;
        for (int w = 0; w < 8; w++) begin
            v[w*32 +: 32] = addr + 32'(b * 32) + 32'(w * 4);
        end
        return v;
    endfunction

    // link-side monitor and ready driver
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = cyc[0];
            default: tx_ready = 1'b0;
        endcase
        if (prev_hold && !(tx_valid && tx_data == prev_data)) hold_err++;
        if (tx_valid && tx_ready) begin
            if (word_cnt < 2048) words[word_cnt] = tx_data;
            word_cnt++;
        end
        prev_hold = tx_valid && !tx_ready;
        prev_data = tx_data;
        if (done) done_cnt++;
    end

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (m_arvalid) begin
                logic [31:0] a;
                int len;
                a = m_araddr;
                len = int'(m_arlen);
                if (m_arlen != 8'd15) bad_len++;
                if (ar_cnt < 16) ar_log[ar_cnt] = a;
                ar_cnt++;
                m_arready = 1'b1;
                @(negedge clk);
                m_arready = 1'b0;
                for (int b = 0; b <= len; b++) begin
                    logic ok;
                    m_rvalid = 1'b1;
                    m_rdata  = make_beat(a, b);
                    m_rlast  = (b == len);
                    ok = 1'b0;
                    while (!ok) begin
                        ok = m_rready;
                        @(negedge clk);
                    end
                    m_rvalid = 1'b0;
                    m_rlast  = 1'b0;
                end
            end
        end
    end

    task automatic clear_logs();
        word_cnt = 0; done_cnt = 0; ar_cnt = 0; bad_len = 0; hold_err = 0;
    endtask

    task automatic pulse_start(input logic [31:0] base, input int n, input logic dat);
        @(negedge clk);
        base_addr  = base;
        word_count = 16'(n);
        is_data    = dat;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(req, (done_cnt > 0) ? 32'd1 : 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_stream(input string req, input logic [31:0] base, input int n, input logic dat);
        int off = dat ? 1 : 0;
        int bad = 0;
        check({req, " word count"}, 32'(word_cnt), 32'(n + off));
        if (dat) check("R5 header word", words[0], 32'h0000_0046);
        for (int i = 0; i < n && i + off < 2048; i++) begin
            if (words[i + off] !== base + 32'(4 * i)) bad++;
        end
        check({req, " R4 payload order"}, 32'(bad), 32'd0);
    endtask

    task automatic check_bursts(input logic [31:0] base, input int n);
        int beats = (n + 7) / 8;
        int exp_b = (beats + 15) / 16;
        int bad = 0;
        check("R3 burst count", 32'(ar_cnt), 32'(exp_b));
        for (int k = 0; k < exp_b && k < 16; k++) begin
            if (ar_log[k] !== base + 32'(512 * k)) bad++;
        end
        check("R2 burst addresses", 32'(bad), 32'd0);
        check("R2 burst length", 32'(bad_len), 32'd0);
    endtask

    task automatic check_end(input string req);
        check({req, " R8 single done"}, 32'(done_cnt), 32'd1);
        check({req, " R8 idle after"}, {31'd0, busy}, 32'd0);
        check({req, " R11 hold"}, 32'(hold_err), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 arvalid", {31'd0, m_arvalid}, 32'd0);
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_frame(input logic [31:0] base, input int n, input logic dat, input int mode, input string req);
        clear_logs();
        ready_mode = mode;
        pulse_start(base, n, dat);
        wait_done(req);
        check_stream(req, base, n, dat);
        check_bursts(base, n);
        check_end(req);
    endtask

    task automatic t_backpressure();
        logic [31:0] base = 32'h0004_0000;
        clear_logs();
        ready_mode = 2;
        pulse_start(base, 1024, 1'b0);
        repeat (400) @(negedge clk);
        check("R3 stalled burst limit", 32'(ar_cnt), 32'd2);
        check("R3 no words while stalled", 32'(word_cnt), 32'd0);
        ready_mode = 0;
        wait_done("R3 backpressure done");
        check_stream("R3", base, 1024, 1'b0);
        check_bursts(base, 1024);
        check_end("R3");
    endtask

    task automatic t_zero();
        clear_logs();
        ready_mode = 0;
        pulse_start(32'h0000_2000, 0, 1'b0);
        wait_done("R10 empty other");
        check("R10 no words", 32'(word_cnt), 32'd0);
        check("R10 no bursts", 32'(ar_cnt), 32'd0);
        check_end("R10");
        clear_logs();
        pulse_start(32'h0000_2000, 0, 1'b1);
        wait_done("R10 empty data");
        check("R10 header only", 32'(word_cnt), 32'd1);
        check("R10 R5 header", words[0], 32'h0000_0046);
        check("R10 no bursts data", 32'(ar_cnt), 32'd0);
        check_end("R10");
    endtask

    task automatic t_start_busy();
        logic [31:0] base = 32'h0001_0000;
        clear_logs();
        ready_mode = 1;
        pulse_start(base, 20, 1'b0);
        repeat (2) @(negedge clk);
        pulse_start(32'h0009_0000, 40, 1'b1);
        wait_done("R9 first frame");
        check_stream("R9", base, 20, 1'b0);
        check_bursts(base, 20);
        check_end("R9");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_frame(32'h0000_1000, 5, 1'b0, 0, "R6 R7 small other");
        t_frame(32'h0000_4000, 300, 1'b1, 1, "R5 R4 data multi");
        t_frame(32'h0000_8000, 8, 1'b0, 0, "R7 one beat");
        t_frame(32'h0000_8000, 128, 1'b1, 1, "R7 one burst");
        t_frame(32'h0002_0000, 129, 1'b0, 0, "R7 burst plus one");
        t_frame(32'h0003_0000, 9, 1'b1, 1, "R7 beat plus one");
        t_backpressure();
        t_zero();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule